// File: doc/BRIEF.md
# UTC Report-Instant Interpolator

This block takes a stream of time-stamped samples from a signal generator whose sample clock drifts slightly against UTC. Each sample carries a value and its time within the current second, counted in ticks. The reports must sit exactly on 20 ms boundaries of UTC, which gives 50 reports per second. For each report the block finds the pair of consecutive samples that brackets the report instant. It then interpolates linearly between them, so it does not just keep every n-th sample.

Each accepted sample is compared against the pending report instant. If the instant falls strictly between the previous sample time and the new one, a sequential divider computes the interpolation weight. Input is held off until the result comes out. If a sample lands exactly on the instant, its value goes out on the next cycle with no division. Every report carries its exact grid timestamp: a tick count within the second that wraps at one second, and a seconds count that the wrap increments.

Top module: `utc_report_interp`

## Requirements
- R1: While reset is held, out_valid is 0 and in_ready is 1.
- R2: The first sample accepted after reset produces no report. It sets the first pending instant to the smallest multiple of REPORT_TICKS that is strictly later than its time. If that multiple reaches TICKS_PER_SEC, the instant is tick 0 with seconds count 1; otherwise the seconds count is 0.
- R3: When prev_time < T < cur_time for the pending instant T, the report value is prev_value + trunc((cur_value − prev_value)·(T − prev_time)/(cur_time − prev_time)). trunc rounds toward zero. The value always lies between the two sample values.
- R4: A sample produces a report only when it brackets the pending instant as in R3 or R5. Every other sample produces none. Each instant is reported exactly once.
- R5: When a sample's time equals the pending instant, the report value is that sample's value, and out_valid rises on the clock edge that accepted the sample.
- R6: out_time is always a multiple of REPORT_TICKS below TICKS_PER_SEC. Each report's timestamp is the previous one plus REPORT_TICKS. When the tick count would reach TICKS_PER_SEC it becomes 0 and out_sec increments by 1.
- R7: After a sample that needs interpolation is accepted, in_ready is 0 until the report is issued. in_ready returns to 1 on the same edge that raises out_valid.
- R8: An in_valid pulse while in_ready is 0 is ignored. It changes neither the sample history nor the pending instant.
- R9: Sample times are taken modulo TICKS_PER_SEC. A pair of samples whose tick count wraps past the second boundary still brackets and interpolates correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_ready | output | 1 | High when a sample can be accepted |
| in_value | input | DATA_W | Signed sample value |
| in_time | input | TIME_W | Sample time within the second, in ticks |
| out_valid | output | 1 | One-cycle report strobe |
| out_value | output | DATA_W | Signed report value |
| out_sec | output | SEC_W | Report seconds count |
| out_time | output | TIME_W | Report time within the second, in ticks |

## Verification
If the pending instant is advanced wrongly, the next report already shows it: its timestamp is off the grid or skips a slot, and a report may come on a sample that brackets nothing. A stale stored previous sample, or an input accepted by mistake while the divider runs, shows up in the value of the very next report. A divider or sign fault gives a value outside the span of the two bracketing samples once the result comes out, about NUM_W cycles after acceptance. A fault in the ready handshake shows on the edge where in_ready rises without a report.

// File: rtl/uri_pkg.sv
package uri_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_DIV   = 2'd2
    } uri_state_e;
endpackage

// File: rtl/uri_grid_seed.sv
module uri_grid_seed #(
    parameter int TICKS_PER_SEC = 1000000,
    parameter int REPORT_TICKS  = 20000,
    parameter int TIME_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic [TIME_W-1:0] t_now,
    output logic [TIME_W-1:0] seed_time,
    output logic              seed_wrap
);
    localparam int GRID_N = TICKS_PER_SEC / REPORT_TICKS;
    localparam int CNT_W  = $clog2(GRID_N + 1);

    logic [GRID_N-1:0] at_or_before;

    for (genvar k = 0; k < GRID_N; k++) begin : g_slot
        localparam logic [TIME_W:0] SLOT_T = (TIME_W+1)'(k * REPORT_TICKS);
        assign at_or_before[k] = ({1'b0, t_now} >= SLOT_T);
    end

    logic [CNT_W-1:0] passed;

    always_comb begin
        passed = '0;
        for (int i = 0; i < GRID_N; i++) begin
            passed = passed + CNT_W'(at_or_before[i]);
        end
        seed_wrap = (passed == CNT_W'(GRID_N));
        seed_time = seed_wrap ? '0 : TIME_W'(32'(passed) * REPORT_TICKS);
    end
endmodule

// File: rtl/uri_seqdiv.sv
module uri_seqdiv #(
    parameter int NUM_W = 37,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             active;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W:0]   rem;
        logic [NUM_W-1:0] acc;
        logic [DEN_W-1:0] den;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0] rem_sh;
    logic           fits;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        rem_sh    = {st_q.rem[DEN_W-1:0], st_q.acc[NUM_W-1]};
        fits      = (rem_sh >= {1'b0, st_q.den});
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = CNT_W'(NUM_W);
            st_d.rem    = '0;
            st_d.acc    = num;
            st_d.den    = den;
        end else if (st_q.active) begin
            st_d.rem = fits ? (rem_sh - {1'b0, st_q.den}) : rem_sh;
            st_d.acc = {st_q.acc[NUM_W-2:0], fits};
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign quo  = st_q.acc;
endmodule

// File: rtl/utc_report_interp.sv
module utc_report_interp
    import uri_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int TICKS_PER_SEC = 1000000,
    parameter int REPORT_TICKS  = 20000,
    parameter int SEC_W         = 32,
    parameter int TIME_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_value,
    input  logic [TIME_W-1:0]        in_time,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_value,
    output logic [SEC_W-1:0]         out_sec,
    output logic [TIME_W-1:0]        out_time
);
    localparam int MAG_W = DATA_W + 1;
    localparam int NUM_W = MAG_W + TIME_W;
    localparam logic [TIME_W-1:0] LAST_SLOT = TIME_W'(TICKS_PER_SEC - REPORT_TICKS);
    localparam logic [TIME_W-1:0] STEP      = TIME_W'(REPORT_TICKS);

    typedef struct packed {
        uri_state_e               st;
        logic [TIME_W-1:0]        prev_t;
        logic signed [DATA_W-1:0] prev_v;
        logic [TIME_W-1:0]        tgt_t;
        logic [SEC_W-1:0]         tgt_s;
        logic signed [DATA_W-1:0] base_v;
        logic                     neg;
        logic [TIME_W-1:0]        hold_t;
        logic [SEC_W-1:0]         hold_s;
        logic                     o_valid;
        logic signed [DATA_W-1:0] o_value;
        logic [TIME_W-1:0]        o_t;
        logic [SEC_W-1:0]         o_s;
    } core_st_t;

    core_st_t st_d, st_q;

    function automatic logic [TIME_W-1:0] fwd_dist(input logic [TIME_W-1:0] to_t,
                                                   input logic [TIME_W-1:0] from_t);
        logic [TIME_W:0] s;
        if (to_t >= from_t) s = {1'b0, to_t} - {1'b0, from_t};
        else s = {1'b0, to_t} + (TIME_W+1)'(TICKS_PER_SEC) - {1'b0, from_t};
        return s[TIME_W-1:0];
    endfunction

    logic [TIME_W-1:0] seed_time;
    logic              seed_wrap;

    uri_grid_seed #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .REPORT_TICKS (REPORT_TICKS),
        .TIME_W       (TIME_W)
    ) u_seed (
        .t_now    (in_time),
        .seed_time(seed_time),
        .seed_wrap(seed_wrap)
    );

    logic             div_start;
    logic [NUM_W-1:0] div_num;
    logic [TIME_W-1:0] div_den;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;

    uri_seqdiv #(
        .NUM_W(NUM_W),
        .DEN_W(TIME_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    logic                    accept;
    logic [TIME_W-1:0]       d_tgt;
    logic [TIME_W-1:0]       d_cur;
    logic signed [MAG_W-1:0] diff_s;
    logic                    diff_neg;
    logic [MAG_W-1:0]        diff_mag;
    logic [TIME_W-1:0]       nxt_t;
    logic [SEC_W-1:0]        nxt_s;
    logic [MAG_W-1:0]        q_mag;
    logic signed [MAG_W:0]   q_signed;
    logic signed [MAG_W:0]   res;

    always_comb begin
        accept   = in_valid && (st_q.st != ST_DIV);
        d_tgt    = fwd_dist(st_q.tgt_t, st_q.prev_t);
        d_cur    = fwd_dist(in_time, st_q.prev_t);
        diff_s   = $signed({in_value[DATA_W-1], in_value}) - $signed({st_q.prev_v[DATA_W-1], st_q.prev_v});
        diff_neg = diff_s[MAG_W-1];
        diff_mag = diff_neg ? MAG_W'(-diff_s) : MAG_W'(diff_s);
        div_num  = NUM_W'(diff_mag) * NUM_W'(d_tgt);
        div_den  = d_cur;

        if (st_q.tgt_t == LAST_SLOT) begin
            nxt_t = '0;
            nxt_s = st_q.tgt_s + 1'b1;
        end else begin
            nxt_t = st_q.tgt_t + STEP;
            nxt_s = st_q.tgt_s;
        end

        q_mag    = div_quo[MAG_W-1:0];
        q_signed = st_q.neg ? -$signed({1'b0, q_mag}) : $signed({1'b0, q_mag});
        res      = $signed({{2{st_q.base_v[DATA_W-1]}}, st_q.base_v}) + q_signed;

        st_d         = st_q;
        st_d.o_valid = 1'b0;
        div_start    = 1'b0;

        unique case (st_q.st)
            ST_EMPTY: begin
                if (accept) begin
                    st_d.prev_t = in_time;
                    st_d.prev_v = in_value;
                    st_d.tgt_t  = seed_time;
                    st_d.tgt_s  = seed_wrap ? SEC_W'(1) : '0;
                    st_d.st     = ST_RUN;
                end
            end
            ST_RUN: begin
                if (accept) begin
                    st_d.prev_t = in_time;
                    st_d.prev_v = in_value;
                    if (d_cur != '0 && d_tgt == d_cur) begin
                        st_d.o_valid = 1'b1;
                        st_d.o_value = in_value;
                        st_d.o_t     = st_q.tgt_t;
                        st_d.o_s     = st_q.tgt_s;
                        st_d.tgt_t   = nxt_t;
                        st_d.tgt_s   = nxt_s;
                    end else if (d_tgt < d_cur) begin
                        div_start   = 1'b1;
                        st_d.base_v = st_q.prev_v;
                        st_d.neg    = diff_neg;
                        st_d.hold_t = st_q.tgt_t;
                        st_d.hold_s = st_q.tgt_s;
                        st_d.tgt_t  = nxt_t;
                        st_d.tgt_s  = nxt_s;
                        st_d.st     = ST_DIV;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    st_d.o_valid = 1'b1;
                    st_d.o_value = res[DATA_W-1:0];
                    st_d.o_t     = st_q.hold_t;
                    st_d.o_s     = st_q.hold_s;
                    st_d.st      = ST_RUN;
                end
            end
            default: st_d.st = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = (st_q.st != ST_DIV);
    assign out_valid = st_q.o_valid;
    assign out_value = st_q.o_value;
    assign out_sec   = st_q.o_s;
    assign out_time  = st_q.o_t;
endmodule

// File: rtl/uri_chk.sv
module uri_chk #(
    parameter int DATA_W        = 16,
    parameter int TICKS_PER_SEC = 1000000,
    parameter int REPORT_TICKS  = 20000,
    parameter int SEC_W         = 32,
    parameter int TIME_W        = $clog2(TICKS_PER_SEC)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic signed [DATA_W-1:0] in_value,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_value,
    input logic [SEC_W-1:0]         out_sec,
    input logic [TIME_W-1:0]        out_time
);
    logic [TIME_W-1:0]        last_t;
    logic [SEC_W-1:0]         last_s;
    logic                     have_last;
    logic signed [DATA_W-1:0] smp_cur;
    logic signed [DATA_W-1:0] smp_prev;
    logic [1:0]               n_smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_t    <= '0;
            last_s    <= '0;
            have_last <= 1'b0;
            smp_cur   <= '0;
            smp_prev  <= '0;
            n_smp     <= '0;
        end else begin
            if (out_valid) begin
                last_t    <= out_time;
                last_s    <= out_sec;
                have_last <= 1'b1;
            end
            if (in_valid && in_ready) begin
                smp_prev <= smp_cur;
                smp_cur  <= in_value;
                if (n_smp != 2'd2) n_smp <= n_smp + 1'b1;
            end
        end
    end

    // R6
    grid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((32'(out_time) % REPORT_TICKS) == 0) && (32'(out_time) < TICKS_PER_SEC));

    // R6
    grid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_last) |->
            ((32'(last_t) + REPORT_TICKS == 32'(out_time)) && (out_sec == last_s)) ||
            ((32'(last_t) + REPORT_TICKS == TICKS_PER_SEC) && (out_time == '0) && (out_sec == last_s + 1'b1)));

    // R7
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> out_valid);

    // R3
    value_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_value >= smp_prev && out_value <= smp_cur) ||
                       (out_value <= smp_prev && out_value >= smp_cur)));

    // R2
    primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (n_smp == 2'd2));
endmodule

bind utc_report_interp uri_chk #(
    .DATA_W       (DATA_W),
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .REPORT_TICKS (REPORT_TICKS),
    .SEC_W        (SEC_W),
    .TIME_W       (TIME_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_value (in_value),
    .out_valid(out_valid),
    .out_value(out_value),
    .out_sec  (out_sec),
    .out_time (out_time)
);

// File: tb/utc_report_interp_tb.sv
module utc_report_interp_tb;
    localparam int DW  = 16;
    localparam int TPS = 1000000;
    localparam int RT  = 20000;
    localparam int SW  = 32;
    localparam int TW  = $clog2(TPS);

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic                 in_ready;
    logic signed [DW-1:0] in_value;
    logic [TW-1:0]        in_time;
    logic                 out_valid;
    logic signed [DW-1:0] out_value;
    logic [SW-1:0]        out_sec;
    logic [TW-1:0]        out_time;

    always #5 clk = ~clk;

    utc_report_interp #(
        .DATA_W(DW), .TICKS_PER_SEC(TPS), .REPORT_TICKS(RT), .SEC_W(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_value(in_value), .in_time(in_time), .out_valid(out_valid),
        .out_value(out_value), .out_sec(out_sec), .out_time(out_time)
    );

    typedef struct {
        longint val;
        longint t;
        bit     exact;
        bit     junk;
    } exp_t;

    exp_t   sb[$];
    int     checks = 0;
    int     fails  = 0;
    int     n_reports = 0;
    bit     primed = 0;
    longint prev_a, tgt_a;
    int     prev_v;

    task automatic check(bit ok, string req, longint act, longint exp, string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int vfun(longint a);
        return int'((a * 7919) % 65536) - 32768;
    endfunction

    task automatic send(longint a, bit add_junk);
        int  v;
        bit  interp;
        exp_t e;
        v = vfun(a);
        interp = 0;
        if (!primed) begin
            primed = 1;
            tgt_a  = (a / RT + 1) * RT;   // R2 first instant strictly later
        end else if (a == tgt_a) begin
            e.val = v; e.t = tgt_a; e.exact = 1; e.junk = 0;
            sb.push_back(e);
            tgt_a += RT;
        end else if (prev_a <= tgt_a && tgt_a < a) begin
            e.val = prev_v + ((longint'(v) - prev_v) * (tgt_a - prev_a)) / (a - prev_a);
            e.t = tgt_a; e.exact = 0; e.junk = add_junk;
            sb.push_back(e);
            tgt_a += RT;
            interp = 1;
        end
        prev_a = a;
        prev_v = v;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_value = DW'(v);
        in_time  = TW'(a % TPS);
        @(negedge clk);
        in_valid = 1'b0;
        if (interp) begin
            check(in_ready == 1'b0, "R7", longint'(in_ready), 0, "ready after interp accept");
            if (add_junk) begin
                in_valid = 1'b1;
                in_value = 16'sh1234;
                in_time  = TW'((a + 5) % TPS);
                repeat (3) @(negedge clk);
                in_valid = 1'b0;
            end
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            exp_t e;
            n_reports++;
            if (sb.size() == 0) begin
                check(0, "R4", longint'(out_time), -1, "unexpected report");
            end else begin
                e = sb.pop_front();
                if (e.exact)
                    check(out_value == DW'(e.val), "R5", longint'(out_value), e.val, "exact-hit value");
                else if (e.junk)
                    check(out_value == DW'(e.val), "R3 R8", longint'(out_value), e.val, "interp value after ignored input");
                else
                    check(out_value == DW'(e.val), "R3", longint'(out_value), e.val, "interp value");
                if (e.t >= TPS)
                    check(out_time == TW'(e.t % TPS) && out_sec == SW'(e.t / TPS), "R6 R9",
                          longint'(out_sec) * TPS + out_time, e.t, "timestamp after wrap");
                else
                    check(out_time == TW'(e.t % TPS) && out_sec == SW'(e.t / TPS), "R6",
                          longint'(out_sec) * TPS + out_time, e.t, "timestamp");
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        longint a;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_value = '0;
        in_time  = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0, "out_valid in reset");
        check(in_ready == 1'b1, "R1", longint'(in_ready), 1, "in_ready in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: priming sample sits on the grid yet reports nothing
        send(0, 0);
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R2", longint'(out_valid), 0, "no report on priming sample");

        // aligned stream: exact hits every 20000 ticks (R5)
        for (int i = 1; i <= 2000; i++) send(longint'(i) * 100, 0);

        // drifting stream across the second boundary (R3, R8, R9)
        a = 200037;
        for (int i = 0; a < 1060000; i++) begin
            a += 97 + (i * 13) % 7;
            send(a, (i % 2) == 0);
        end

        repeat (100) @(negedge clk);
        check(sb.size() == 0, "R4", longint'(sb.size()), 0, "reports still owed");
        check(n_reports == 53, "R4", longint'(n_reports), 53, "report count");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule